// File: doc/BRIEF.md
# Interrupt Trigger Conditioner

This block conditions raw interrupt lines before they reach an interrupt controller. Each of the 64 lines passes through a two-flop synchroniser. The line then becomes a level request. A pair of per-line configuration bits, rise and fall, selects how the request is formed: it can follow the input, follow the inverted input, or come from a sticky latch that captures one chosen transition.

Software reaches the block over a simple word-addressed register bus. The lines are split into 32-line banks. Each bank has a read-only status view of the conditioned requests and a raw-status view of the sticky latches. Writing a one to a raw-status bit acknowledges that latch. Each bank also has directly writable rise and fall configuration words, plus set and clear aliases for each. The aliases let one line be reconfigured without a read-modify-write. Masking and routing of the requests happen downstream.

Top module: `trig_cond`

## Requirements
- R1: After reset all rise and fall configuration bits are 0, all sticky latches are 0, and with all inputs low every conditioned output and every register read returns 0.
- R2: Every raw input passes through two flops before use, so a change on a line in level mode shows on its conditioned output two clock edges after the input changes.
- R3: With rise=0 and fall=0 the line is active-high level: the output equals the synchronised input.
- R4: With rise=1 and fall=1 the line is active-low level: the output equals the inverted synchronised input.
- R5: With rise=1 and fall=0 the sticky latch sets on a synchronised 0-to-1 transition, and the output equals the latch. The output rises three edges after the input rises.
- R6: With rise=0 and fall=1 the sticky latch sets on a synchronised 1-to-0 transition, and the output equals the latch.
- R7: A write to raw status (word index 1 within a bank) clears each latch whose data bit is 1 and leaves latches whose data bit is 0 unchanged. Writing all ones clears every latch in the bank.
- R8: If a selected transition and an acknowledge of the same line fall in the same cycle, the latch stays set.
- R9: The word index within a bank is taken from address bits [2:0], with this map: 2 is rise configuration, 3 is fall configuration, 4 is rise-set, 5 is rise-clear, 6 is fall-set and 7 is fall-clear. Writes to 2 and 3 replace the word. The alias writes change only the bits written as 1.
- R10: Address bit 3 selects the bank. Bank 0 holds lines 0 to 31 and bank 1 holds lines 32 to 63, which places the upper bank 0x20 bytes above the lower one.
- R11: Word index 0 reads the bank's 32 conditioned outputs, and writes to it have no effect. Word index 1 reads the latches, 2 and 3 read the configuration, and the alias indices 4 to 7 read 0.
- R12: In both level modes the sticky latch is held at 0 and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | 64 | Raw interrupt lines, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Word address: bit 3 is the bank, bits 2:0 are the register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_cond_o | output | 64 | Conditioned level requests to the interrupt controller |

## Verification
The assertions assume that only one register write happens per cycle, so a set alias and a clear alias never reach the same word together. They also assume that reg_addr_i and reg_wdata_i are stable and defined whenever reg_we_i is high. The stimulus drives every input once per cycle, half a period away from the active edge, and issues at most one write per call. In the random phase both the raw lines and the write targets are drawn freely, including raw-status acknowledges that land on cycles where an edge is being detected.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int REG_IDX_W = 3;

  // word index inside a bank
  localparam logic [REG_IDX_W-1:0] IDX_STAT     = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_LATCH    = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_RISE     = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_FALL     = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_RISE_SET = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_RISE_CLR = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_FALL_SET = 3'd6;
  localparam logic [REG_IDX_W-1:0] IDX_FALL_CLR = 3'd7;

  // {fall, rise}
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_RISE   = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_LVL_LO = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int BANK_W  = 32,
  localparam int N_BANKS    = N_LINES / BANK_W,
  localparam int BANK_IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int ADDR_W     = REG_IDX_W + BANK_IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o,
  output logic [N_LINES-1:0] ack_o
);
  logic [N_BANKS-1:0][BANK_W-1:0] rise_b, fall_b, ack_b;
  logic [REG_IDX_W-1:0]  idx;
  logic [BANK_IDX_W-1:0] bank;

  assign idx  = addr_i[REG_IDX_W-1:0];
  assign bank = addr_i[REG_IDX_W +: BANK_IDX_W];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic              hit;
    logic [BANK_W-1:0] rise_q, fall_q;

    assign hit = we_i && (bank == BANK_IDX_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= '0;
        fall_q <= '0;
      end else if (hit) begin
        unique case (idx)
          IDX_RISE:     rise_q <= wdata_i;
          IDX_FALL:     fall_q <= wdata_i;
          IDX_RISE_SET: rise_q <= rise_q | wdata_i;
          IDX_RISE_CLR: rise_q <= rise_q & ~wdata_i;
          IDX_FALL_SET: fall_q <= fall_q | wdata_i;
          IDX_FALL_CLR: fall_q <= fall_q & ~wdata_i;
          default: ;
        endcase
      end
    end

    assign rise_b[b] = rise_q;
    assign fall_b[b] = fall_q;
    assign ack_b[b]  = (hit && idx == IDX_LATCH) ? wdata_i : '0;
  end

  assign rise_o = rise_b;
  assign fall_o = fall_b;
  assign ack_o  = ack_b;
endmodule

// File: rtl/trig_line.sv
module trig_line
  import trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic ack_i,
  output logic cond_o,
  output logic sticky_o
);
  trig_mode_e mode;
  logic       prev_q, sticky_q, hit;

  assign mode = trig_mode_e'({fall_en_i, rise_en_i});

  always_comb begin
    unique case (mode)
      TRIG_RISE: hit = lvl_i & ~prev_q;
      TRIG_FALL: hit = ~lvl_i & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // new edge wins over a same-cycle acknowledge
      if (mode == TRIG_RISE || mode == TRIG_FALL) sticky_q <= hit | (sticky_q & ~ack_i);
      else                                        sticky_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_LVL_HI: cond_o = lvl_i;
      TRIG_LVL_LO: cond_o = ~lvl_i;
      default:     cond_o = sticky_q;
    endcase
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import trig_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int BANK_W  = 32,
  localparam int N_BANKS    = N_LINES / BANK_W,
  localparam int BANK_IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int ADDR_W     = REG_IDX_W + BANK_IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_raw_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [BANK_W-1:0]  reg_wdata_i,
  output logic [BANK_W-1:0]  reg_rdata_o,
  output logic [N_LINES-1:0] irq_cond_o
);
  logic [N_LINES-1:0] lvl, rise_cfg, fall_cfg, ack_mask, sticky;

  trig_sync #(.W(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_raw_i),
    .q_o    (lvl)
  );

  trig_cfg_regs #(.N_LINES(N_LINES), .BANK_W(BANK_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rise_o  (rise_cfg),
    .fall_o  (fall_cfg),
    .ack_o   (ack_mask)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    trig_line u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl[i]),
      .rise_en_i (rise_cfg[i]),
      .fall_en_i (fall_cfg[i]),
      .ack_i     (ack_mask[i]),
      .cond_o    (irq_cond_o[i]),
      .sticky_o  (sticky[i])
    );
  end

  logic [N_BANKS-1:0][BANK_W-1:0] cond_b, sticky_b, rise_b, fall_b;
  logic [BANK_IDX_W-1:0]          rd_bank;

  assign cond_b   = irq_cond_o;
  assign sticky_b = sticky;
  assign rise_b   = rise_cfg;
  assign fall_b   = fall_cfg;
  assign rd_bank  = reg_addr_i[REG_IDX_W +: BANK_IDX_W];

  always_comb begin
    unique case (reg_addr_i[REG_IDX_W-1:0])
      IDX_STAT:  reg_rdata_o = cond_b[rd_bank];
      IDX_LATCH: reg_rdata_o = sticky_b[rd_bank];
      IDX_RISE:  reg_rdata_o = rise_b[rd_bank];
      IDX_FALL:  reg_rdata_o = fall_b[rd_bank];
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/trig_cond_chk.sv
module trig_cond_chk
  import trig_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int BANK_W  = 32,
  localparam int N_BANKS    = N_LINES / BANK_W,
  localparam int BANK_IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int ADDR_W     = REG_IDX_W + BANK_IDX_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [BANK_W-1:0]  wdata_i,
  input logic [BANK_W-1:0]  rdata_i,
  input logic [N_LINES-1:0] cond_i,
  input logic [N_LINES-1:0] rise_i,
  input logic [N_LINES-1:0] fall_i,
  input logic [N_LINES-1:0] sticky_i,
  input logic [N_LINES-1:0] ack_i
);
  logic                 bank0;
  logic [REG_IDX_W-1:0] idx;
  assign bank0 = addr_i[REG_IDX_W +: BANK_IDX_W] == '0;
  assign idx   = addr_i[REG_IDX_W-1:0];

  assert_lvl_no_latch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_i & ~$past(rise_i ^ fall_i)) == '0));

  assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sticky_i) & ~sticky_i & ~$past(ack_i) & $past(rise_i ^ fall_i)) == '0));

  assert_rise_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && bank0 && idx == IDX_RISE_SET) |=>
      ((rise_i[BANK_W-1:0] & $past(wdata_i)) == $past(wdata_i)));

  assert_fall_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && bank0 && idx == IDX_FALL_CLR) |=> ((fall_i[BANK_W-1:0] & $past(wdata_i)) == '0));

  assert_status_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank0 && idx == IDX_STAT) |-> (rdata_i == cond_i[BANK_W-1:0]));

  assert_alias_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx >= IDX_RISE_SET) |-> (rdata_i == '0));
endmodule

bind trig_cond trig_cond_chk #(.N_LINES(N_LINES), .BANK_W(BANK_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .rdata_i  (reg_rdata_o),
  .cond_i   (irq_cond_o),
  .rise_i   (rise_cfg),
  .fall_i   (fall_cfg),
  .sticky_i (sticky),
  .ack_i    (ack_mask)
);

// File: tb/trig_cond_tb.sv
module trig_cond_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] raw_i = '0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] cond_o;

  always #4 clk = ~clk;

  trig_cond u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_raw_i   (raw_i),
    .reg_we_i    (we_i),
    .reg_addr_i  (addr_i),
    .reg_wdata_i (wdata_i),
    .reg_rdata_o (rdata_o),
    .irq_cond_o  (cond_o)
  );

  int    n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";
  logic [63:0] cur_in = '0;
  logic [3:0]  cur_addr = '0;

  // reference model state
  logic [63:0] m_hist[$];
  logic [63:0] m_rise = '0, m_fall = '0, m_stk = '0;

  function automatic logic [63:0] exp_cond();
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (m_rise[i] && m_fall[i])        r[i] = !m_hist[1][i];
      else if (!m_rise[i] && !m_fall[i]) r[i] = m_hist[1][i];
      else                               r[i] = m_stk[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    int base = a[3] ? 32 : 0;
    logic [63:0] c = exp_cond();
    case (a[2:0])
      3'd0:    return c[base +: 32];
      3'd1:    return m_stk[base +: 32];
      3'd2:    return m_rise[base +: 32];
      3'd3:    return m_fall[base +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_edge(logic [63:0] in, logic we, logic [3:0] a, logic [31:0] wd);
    int base = a[3] ? 32 : 0;
    logic [63:0] ack = '0;
    logic [63:0] now_lvl = m_hist[1], old_lvl = m_hist[2];
    if (we && a[2:0] == 3'd1) ack[base +: 32] = wd;
    for (int i = 0; i < 64; i++) begin
      bit ev;
      if (m_rise[i] == m_fall[i]) m_stk[i] = 1'b0;
      else begin
        ev = m_rise[i] ? (now_lvl[i] && !old_lvl[i]) : (!now_lvl[i] && old_lvl[i]);
        if (ev) m_stk[i] = 1'b1;
        else if (ack[i]) m_stk[i] = 1'b0;
      end
    end
    if (we) begin
      case (a[2:0])
        3'd2: m_rise[base +: 32] = wd;
        3'd3: m_fall[base +: 32] = wd;
        3'd4: m_rise[base +: 32] = m_rise[base +: 32] | wd;
        3'd5: m_rise[base +: 32] = m_rise[base +: 32] & ~wd;
        3'd6: m_fall[base +: 32] = m_fall[base +: 32] | wd;
        3'd7: m_fall[base +: 32] = m_fall[base +: 32] & ~wd;
        default: ;
      endcase
    end
    m_hist.push_front(in);
    void'(m_hist.pop_back());
  endtask

  task automatic compare();
    logic [63:0] ec = exp_cond();
    logic [31:0] er = exp_rd(addr_i);
    n_chk++;
    if (cond_o !== ec) begin
      n_err++;
      $display("FAIL %s cond cyc=%0d actual=%h expected=%h", cur_req, cyc, cond_o, ec);
    end
    n_chk++;
    if (rdata_o !== er) begin
      n_err++;
      $display("FAIL %s rdata addr=%h cyc=%0d actual=%h expected=%h", cur_req, addr_i, cyc, rdata_o, er);
    end
  endtask

  task automatic tick(logic [63:0] in, logic we, logic [3:0] a, logic [31:0] wd);
    raw_i = in; we_i = we; addr_i = a; wdata_i = wd;
    model_edge(in, we, a, wd);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(cur_in, 1'b0, cur_addr, 32'h0);
  endtask
  task automatic drive(logic [63:0] v);
    cur_in = v;
    tick(cur_in, 1'b0, cur_addr, 32'h0);
  endtask
  task automatic wr(logic [3:0] a, logic [31:0] d);
    tick(cur_in, 1'b1, a, d);
  endtask
  task automatic rd(logic [3:0] a);
    cur_addr = a;
    tick(cur_in, 1'b0, a, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    m_hist = '{64'h0, 64'h0, 64'h0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    compare();
    for (int a = 0; a < 16; a++) rd(4'(a));

    cur_req = "R3";   // also latency of R2
    rd(4'h0);
    drive(64'h0000_0001_8000_0001); idle(3);
    drive(64'hA5A5_0000_0000_5A5A); idle(2);
    drive(64'h0); idle(2);

    cur_req = "R4";
    wr(4'h2, 32'h0000_FFFF);
    wr(4'h3, 32'h0000_FFFF);
    rd(4'h0);
    drive(64'h0000_0000_0000_00F0); idle(3);
    drive(64'h0000_0000_0000_FF0F); idle(3);

    cur_req = "R5";
    wr(4'h4, 32'h00FF_0000);
    rd(4'h1);
    drive(64'h0000_0000_0001_0000); idle(4);
    drive(64'h0000_0000_0000_0000); idle(3);
    drive(64'h0000_0000_0003_0000); idle(2);

    cur_req = "R6";
    wr(4'h6, 32'hFF00_0000);
    drive(64'h0000_0000_FF03_0000); idle(4);
    drive(64'h0000_0000_5503_0000); idle(4);
    rd(4'h0);

    cur_req = "R7";
    rd(4'h1);
    wr(4'h1, 32'h0001_0000);
    idle(1);
    wr(4'h1, 32'h0000_0000);
    idle(1);
    wr(4'h1, 32'hFFFF_FFFF);
    idle(2);

    cur_req = "R8";
    drive(64'h0000_0000_5500_0000);
    idle(3);
    drive(64'h0000_0000_5501_0000);   // rise on line 16
    idle(1);
    wr(4'h1, 32'h0001_0000);          // ack lands with the detected edge
    rd(4'h1); idle(2);

    cur_req = "R10";
    wr(4'hC, 32'h0000_000F);
    wr(4'hA, 32'hF000_0000);
    wr(4'hB, 32'hF000_0000);
    rd(4'h9);
    drive(64'h0000_0005_5501_0000); idle(4);
    rd(4'h8); idle(2);
    wr(4'h9, 32'hFFFF_FFFF);
    rd(4'h9);

    cur_req = "R9";
    rd(4'h2);
    wr(4'h5, 32'h00F0_0000);
    wr(4'h7, 32'hF000_0000);
    rd(4'h3);
    wr(4'h2, 32'h1234_5678);
    rd(4'h2);
    wr(4'hD, 32'h0000_0003);
    rd(4'hA);

    cur_req = "R11";
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8);
    for (int a = 4; a < 8; a++) rd(4'(a));

    cur_req = "R12";
    wr(4'h2, 32'h000F_0000);
    wr(4'h3, 32'h0000_0000);
    drive(64'h0000_0000_0000_0000); idle(4);
    rd(4'h1);
    wr(4'h3, 32'h000F_0000);
    idle(2);

    cur_req = "R2";
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      cur_in = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) tick(cur_in, 1'b1, a, $urandom());
      else tick(cur_in, 1'b0, a, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule